// File: doc/BRIEF.md
# Shared GPIO and Segment Pin Controller

This block manages a bank of pins. Each pin works either as a display segment output or as a general-purpose digital I/O. A per-pin function bit chooses between the two roles. In I/O mode a per-pin direction bit chooses input or output. A simple synchronous register bus writes the configuration and reads it back. The same bus writes the output data and reads the pin levels.

The output data register always accepts writes, whatever role the pin has at the time. A pin shows the stored value only while it is an I/O output. At every other time the value stays hidden from the pin and from reads. Each pin also carries a small selector that sends its level to one of several internal resource lines, for example an interrupt source or a timer gate. This routing also works while the pin drives as an output, so logic inside the chip can watch the level that is driven.

Top module: `pinmux_bank`

## Requirements
- R1: After a synchronous reset all function, direction, data and selector bits are 0. Every pin is then an I/O input with output enable low, and every resource line is low.
- R2: Function bit 1 makes the pin a segment pin. Its output enable is high and its output carries the matching `seg_drv` bit.
- R3: With function bit 0, direction bit 1 makes the pin drive its data bit with output enable high. Direction bit 0 gives output enable low and an output of 0.
- R4: A write to address 0 stores `bus_wdata` in the data register in every pin mode, including segment mode and input mode.
- R5: While a pin is not an I/O output, its stored data bit shows neither on `pad_out` nor in the address 0 read. In the cycle after a configuration write makes the pin an I/O output, the stored bit appears on both.
- R6: When a pin is not an I/O output, its address 0 read bit returns `pad_in` through a two-flop synchronizer. A change of level first shows after the second rising clock edge.
- R7: When a pin is an I/O output, its address 0 read bit returns the driven data bit.
- R8: Selector code 0 attaches no resource. Code k, from 1 to 7, drives `res_out[k-1]`, which is the OR of the levels of all I/O pins set to code k. Segment pins add nothing to any resource line.
- R9: The routed level of an I/O output pin is its driven data bit. The routed level of an I/O input pin is its synchronized input.
- R10: The address map has four kinds of entry. Address 0 is data on write and pin levels on read. Address 1 holds direction, with bit i for pin i. Address 2 holds function, with bit i for pin i. Address 3+i holds the selector of pin i in bits [2:0]. Direction, function and selector values read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Combinational read data for `bus_addr` |
| pad_in | input | NPINS | Pin input levels, asynchronous |
| pad_out | output | NPINS | Pin output levels |
| pad_oe | output | NPINS | Pin output enables |
| seg_drv | input | NPINS | Segment drive levels for pins in segment mode |
| res_out | output | 2**SELW-1 | Routed resource lines, bit k-1 for code k |

## Verification
The bench walks through every combination of function, direction and data bits on a four-pin bank. It compares pin drive, output enable and readback against values worked out bit by bit. A design that leaked hidden data onto an input pin or a segment pin would fail here, and so would one that ignored a write made while a pin was not an output. Separate checks cover two more cases. One is the stored value appearing in the cycle after the pin turns into an output. The other is the exact two-edge delay of the input synchronizer, which a design with one flop or three flops would miss. Selector sweeps put every code on every pin, in both input and output mode. They catch code 0 being routed, lines being swapped, and segment pins leaking onto a resource line.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
   // fixed address slots; selector slots follow from SEL_BASE
   localparam int ADDR_DATA = 0;
   localparam int ADDR_DIR  = 1;
   localparam int ADDR_MAP  = 2;
   localparam int SEL_BASE  = 3;

   function automatic int slot_count(input int npins);
      return SEL_BASE + npins;
   endfunction

   function automatic int addr_width(input int npins);
      return (slot_count(npins) <= 2) ? 1 : $clog2(slot_count(npins));
   endfunction
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_a;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_a <= '0;
         q       <= '0;
      end else begin
         stage_a <= d;
         q       <= stage_a;
      end
   end
endmodule

// File: rtl/pinmux_cell.sv
module pinmux_cell (
   input  logic is_seg,
   input  logic is_out,
   input  logic data_bit,
   input  logic seg_bit,
   input  logic sync_bit,
   output logic drv,
   output logic oe,
   output logic rd_bit,
   output logic lvl,
   output logic lvl_en
);
   logic io_out;

   always_comb begin
      io_out = !is_seg && is_out;
      oe     = is_seg || is_out;
      if (is_seg)      drv = seg_bit;
      else if (io_out) drv = data_bit;
      else             drv = 1'b0;
      rd_bit = io_out ? data_bit : sync_bit;
      lvl    = io_out ? data_bit : sync_bit;
      lvl_en = !is_seg;
   end
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route #(
   parameter int NPINS = 8,
   parameter int SELW  = 3,
   localparam int NRES = (1 << SELW) - 1
) (
   input  logic [NPINS*SELW-1:0] sel_flat,
   input  logic [NPINS-1:0]      lvl,
   input  logic [NPINS-1:0]      lvl_en,
   output logic [NRES-1:0]       res
);
   for (genvar k = 1; k <= NRES; k++) begin : g_line
      logic [NPINS-1:0] hit;
      always_comb begin
         for (int i = 0; i < NPINS; i++) begin
            hit[i] = lvl_en[i] && lvl[i] &&
                     (sel_flat[i*SELW +: SELW] == SELW'(k));
         end
      end
      assign res[k-1] = |hit;
   end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank #(
   parameter int NPINS = 8,
   parameter int SELW  = 3,
   localparam int AW   = pinmux_pkg::addr_width(NPINS),
   localparam int NRES = (1 << SELW) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   input  logic [NPINS-1:0] seg_drv,
   output logic [NRES-1:0]  res_out
);
   import pinmux_pkg::*;

   // elaboration-time parameter checks
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("pinmux_bank: NPINS must be 1..32");
   end
   if (SELW < 1 || SELW > 4) begin : g_bad_selw
      $error("pinmux_bank: SELW must be 1..4");
   end
   if (NPINS < SELW) begin : g_bad_bus
      $error("pinmux_bank: bus narrower than selector field");
   end

   logic [NPINS-1:0]      map_q, dir_q, data_q, sync_q;
   logic [NPINS*SELW-1:0] sel_flat;
   logic [NPINS-1:0]      rd_pin, lvl, lvl_en;

   // configuration and data registers
   always_ff @(posedge clk) begin
      if (rst) begin
         map_q  <= '0;
         dir_q  <= '0;
         data_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == AW'(ADDR_DATA)) data_q <= bus_wdata;
         if (bus_addr == AW'(ADDR_DIR))  dir_q  <= bus_wdata;
         if (bus_addr == AW'(ADDR_MAP))  map_q  <= bus_wdata;
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [SELW-1:0] sel_q;

      always_ff @(posedge clk) begin
         if (rst)
            sel_q <= '0;
         else if (bus_we && bus_addr == AW'(SEL_BASE + i))
            sel_q <= bus_wdata[SELW-1:0];
      end
      assign sel_flat[i*SELW +: SELW] = sel_q;

      pinmux_cell u_cell (
         .is_seg   (map_q[i]),
         .is_out   (dir_q[i]),
         .data_bit (data_q[i]),
         .seg_bit  (seg_drv[i]),
         .sync_bit (sync_q[i]),
         .drv      (pad_out[i]),
         .oe       (pad_oe[i]),
         .rd_bit   (rd_pin[i]),
         .lvl      (lvl[i]),
         .lvl_en   (lvl_en[i])
      );
   end

   pinmux_sync #(.W(NPINS)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pad_in),
      .q   (sync_q)
   );

   pinmux_route #(.NPINS(NPINS), .SELW(SELW)) u_route (
      .sel_flat (sel_flat),
      .lvl      (lvl),
      .lvl_en   (lvl_en),
      .res      (res_out)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(ADDR_DATA))     bus_rdata = rd_pin;
      else if (bus_addr == AW'(ADDR_DIR)) bus_rdata = dir_q;
      else if (bus_addr == AW'(ADDR_MAP)) bus_rdata = map_q;
      else begin
         for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == AW'(SEL_BASE + i))
               bus_rdata = NPINS'(sel_flat[i*SELW +: SELW]);
         end
      end
   end
endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk #(
   parameter int NPINS = 8,
   parameter int SELW  = 3,
   parameter int AW    = 4,
   localparam int NRES = (1 << SELW) - 1
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  bus_we,
   input logic [AW-1:0]         bus_addr,
   input logic [NPINS-1:0]      bus_wdata,
   input logic [NPINS-1:0]      bus_rdata,
   input logic [NPINS-1:0]      pad_out,
   input logic [NPINS-1:0]      pad_oe,
   input logic [NPINS-1:0]      seg_drv,
   input logic [NRES-1:0]       res_out,
   input logic [NPINS-1:0]      map_q,
   input logic [NPINS-1:0]      dir_q,
   input logic [NPINS-1:0]      data_q,
   input logic [NPINS-1:0]      sync_q,
   input logic [NPINS*SELW-1:0] sel_flat
);
   p_seg_drive_r2: assert property (@(posedge clk) disable iff (rst)
      ((map_q & ~pad_oe) == '0) && ((map_q & (pad_out ^ seg_drv)) == '0));

   p_io_drive_r3: assert property (@(posedge clk) disable iff (rst)
      (((~map_q & dir_q) & (~pad_oe | (pad_out ^ data_q))) == '0));

   p_store_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == '0) |=> (data_q == $past(bus_wdata)));

   p_hidden_r5: assert property (@(posedge clk) disable iff (rst)
      (((~map_q & ~dir_q) & (pad_oe | pad_out)) == '0));

   p_input_read_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == '0) |-> (((~(~map_q & dir_q)) & (bus_rdata ^ sync_q)) == '0));

   p_no_route_r8: assert property (@(posedge clk) disable iff (rst)
      (sel_flat == '0) |-> (res_out == '0));

   p_seg_no_route_r8: assert property (@(posedge clk) disable iff (rst)
      (map_q == '1) |-> (res_out == '0));
endmodule

bind pinmux_bank pinmux_bank_chk #(.NPINS(NPINS), .SELW(SELW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .seg_drv   (seg_drv),
   .res_out   (res_out),
   .map_q     (map_q),
   .dir_q     (dir_q),
   .data_q    (data_q),
   .sync_q    (sync_q),
   .sel_flat  (sel_flat)
);

// File: tb/sim_pinmux_bank.sv
`timescale 1ns/1ps
module sim_pinmux_bank;
   localparam int N    = 4;
   localparam int SW   = 3;
   localparam int AW   = pinmux_pkg::addr_width(N);
   localparam int NRES = (1 << SW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [N-1:0]  bus_wdata = '0;
   logic [N-1:0]  bus_rdata;
   logic [N-1:0]  pad_in = 4'b0011;
   logic [N-1:0]  pad_out, pad_oe;
   logic [N-1:0]  seg_drv = '0;
   logic [NRES-1:0] res_out;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pinmux_bank #(.NPINS(N), .SELW(SW)) u0 (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .seg_drv(seg_drv), .res_out(res_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = N'(d);
      @(negedge clk);
      bus_we = 1'b0;
      #1;
   endtask

   task automatic rd(input int a, output int v);
      bus_addr = AW'(a);
      #1;
      v = int'(bus_rdata);
   endtask

   function automatic int exp_res(input int s, input int lv);
      int r = 0;
      for (int i = 0; i < N; i++) begin
         int code = (s + i) % 8;
         if (code != 0 && lv[i]) r |= (1 << (code - 1));
      end
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check("R1 oe", int'(pad_oe), 0);
      check("R1 out", int'(pad_out), 0);
      check("R1 res", int'(res_out), 0);
      for (int a = 1; a < 3 + N; a++) begin
         rd(a, v); check("R1 reg", v, 0);
      end
      rd(0, v); check("R1 pin read", v, 4'b0011);

      // R6: two-edge synchronizer latency
      @(negedge clk); pad_in = 4'b1100;
      @(negedge clk); #1; rd(0, v); check("R6 after one edge", v, 4'b0011);
      @(negedge clk); #1; rd(0, v); check("R6 after two edges", v, 4'b1100);
      pad_in = 4'b0011;
      repeat (3) @(negedge clk);

      // R2 R3 R5 R7: exhaustive over function, direction, data
      for (int m = 0; m < 16; m++) begin
         for (int d = 0; d < 16; d++) begin
            for (int x = 0; x < 16; x++) begin
               int io_out, e_out, e_rd;
               seg_drv = N'(x ^ 4'b0110);
               wr(2, m); wr(1, d); wr(0, x);
               io_out = ~m & d & 4'hF;
               e_out  = (m & (x ^ 4'b0110)) | (io_out & x);
               e_rd   = (io_out & x) | (~io_out & 4'hF & 4'b0011);
               check("R2 R3 oe", int'(pad_oe), (m | d) & 4'hF);
               check("R2 R3 R5 out", int'(pad_out), e_out);
               rd(0, v); check("R5 R6 R7 read", v, e_rd);
            end
         end
      end
      seg_drv = '0;

      // R4 R5: write while hidden, then reveal
      wr(2, 0); wr(1, 0); wr(0, 4'b1010);
      check("R5 hidden out", int'(pad_out), 0);
      rd(0, v); check("R5 hidden read", v, 4'b0011);
      wr(1, 4'hF);
      check("R4 R5 revealed out", int'(pad_out), 4'b1010);
      rd(0, v); check("R4 R7 revealed read", v, 4'b1010);
      wr(2, 4'hF); wr(0, 4'b0101);
      check("R2 segment out", int'(pad_out), 0);
      wr(2, 0);
      check("R4 stored in segment mode", int'(pad_out), 4'b0101);

      // R10: register readback
      wr(1, 4'b1001); wr(2, 4'b0110);
      rd(1, v); check("R10 dir", v, 4'b1001);
      rd(2, v); check("R10 map", v, 4'b0110);
      for (int i = 0; i < N; i++) wr(3 + i, (5 + 3 * i) % 8);
      for (int i = 0; i < N; i++) begin
         rd(3 + i, v); check("R10 selector", v, (5 + 3 * i) % 8);
      end

      // R8 R9: routing sweep, outputs then inputs
      for (int s = 0; s < 8; s++) begin
         wr(2, 0);
         for (int i = 0; i < N; i++) wr(3 + i, (s + i) % 8);
         wr(1, 4'hF);
         for (int lv = 0; lv < 16; lv++) begin
            wr(0, lv);
            check("R8 R9 route output", int'(res_out), exp_res(s, lv));
         end
         wr(0, 0); wr(1, 0);
         for (int lv = 0; lv < 16; lv += 5) begin
            @(negedge clk); pad_in = N'(lv);
            repeat (3) @(negedge clk); #1;
            check("R8 R9 route input", int'(res_out), exp_res(s, lv));
         end
         wr(2, 4'hF);
         check("R8 segment no route", int'(res_out), 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule